// File: doc/BRIEF.md
# Serial Transmit Channel with Sixteenth-Bit Stop Control

This block is one asynchronous serial transmit channel. A free-running 16x tick enable from outside paces it, so one bit time is sixteen ticks. Each character is framed as a low start bit, then 5 to 8 data bits sent least significant bit first, then an optional parity or flag bit, then a high stop period. The stop period is set in steps of one sixteenth of a bit.

The channel has a one-character holding register in front of a shift register. Software-side logic writes a byte when the ready flag shows the holding register is free. The empty flag shows that the holding register and the shifter are both idle. Enable and disable pulses gate the channel. An optional clear-to-send input can hold back the start of new characters. A request-to-send output can be set to drop by itself once the channel has drained.

Top module: `serial_tx_chan`

## Requirements
- R1: While idle, `txd` is high. A character starts with 16 ticks of low, followed by the data bits, 16 ticks each, least significant bit first. `len_code` 00/01/10/11 selects 5/6/7/8 data bits.
- R2: `par_mode` 00 appends a computed parity bit, with `par_type` 0 for even and 1 for odd. 10 appends no parity bit. In 01 (forced) and 11 (multidrop flag), the appended bit equals `par_type`. The appended bit lasts 16 ticks.
- R3: The stop period is high and lasts 9+n ticks for `stop_code` n from 0 to 7, and 17+n ticks for n from 8 to 15.
- R4: When `len_code` is 00 (5 data bits), codes 0 to 7 get 8 more stop ticks. Codes 8 to 15 are unchanged.
- R5: A write (`wr_en`) while the channel is disabled is ignored. No character is sent, and `tx_emt` stays high.
- R6: `tx_rdy` is high when the channel is enabled and the holding register is empty. `tx_emt` is high when the holding register and the shifter are both empty. `tx_emt` rises exactly when the last stop tick ends. After reset the channel is disabled.
- R7: A character waiting in the holding register starts its start bit on the tick right after the previous stop period, with no idle gap.
- R8: With `cts_gate` high, a character starts only while `cts_in` is high. Dropping `cts_in` during a character does not cut it short.
- R9: A disable pulse during a character lets that character finish, including its full stop period. `tx_rdy` is low while the channel is disabled.
- R10: `rts_set` drives `rts_out` high and `rts_clr` drives it low. With `rts_auto` high, `rts_out` goes low one clock after `tx_emt` rises. With `rts_auto` low, it stays high.
- R11: The line advances only on clocks where `tick16` is high. With no tick, a loaded character does not start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick16 | input | 1 | 16x bit-rate enable |
| cmd_tx_en | input | 1 | Enable pulse |
| cmd_tx_dis | input | 1 | Disable pulse (wins over enable) |
| wr_en | input | 1 | Write strobe for the holding register |
| wr_data | input | 8 | Character to send |
| len_code | input | 2 | Data bits: 00=5, 01=6, 10=7, 11=8 |
| par_mode | input | 2 | 00 computed, 01 forced, 10 none, 11 multidrop flag |
| par_type | input | 1 | Odd select, or value of forced bit or flag |
| stop_code | input | 4 | Stop period code |
| cts_gate | input | 1 | Makes starts depend on cts_in |
| cts_in | input | 1 | Clear-to-send, high = asserted |
| rts_auto | input | 1 | Drop rts_out when the channel empties |
| rts_set | input | 1 | Assert rts_out |
| rts_clr | input | 1 | Negate rts_out |
| txd | output | 1 | Serial line |
| tx_rdy | output | 1 | Holding register free and channel enabled |
| tx_emt | output | 1 | Holding register and shifter both empty |
| rts_out | output | 1 | Request-to-send, high = asserted |

## Verification
The bench times the high level after the last data or parity bit for every stop code, with 5-bit and 8-bit characters, by watching when `tx_emt` rises. A design that forgot the half-bit adjustment, or applied it to codes 8 to 15, would raise that flag eight ticks early or late. Back-to-back characters are checked for a start bit exactly at the end of the stop period, which catches an extra idle tick. Two cases check that a started character is never truncated: dropping clear-to-send mid-character, and disabling the channel mid-character. The remaining cases check that a write to a disabled channel is discarded and that request-to-send is released exactly one clock after the channel drains.

// File: rtl/stx_pkg.sv
package stx_pkg;

    localparam int TICKS_PER_BIT = 16;
    localparam int MAX_DATA      = 8;
    localparam int CODE_W        = 4;
    localparam int CNT_W         = $clog2(2 * TICKS_PER_BIT + 1);
    localparam int IDX_W         = $clog2(MAX_DATA);

    typedef enum logic [1:0] {
        PAR_CALC  = 2'b00,
        PAR_FORCE = 2'b01,
        PAR_NONE  = 2'b10,
        PAR_MDROP = 2'b11
    } par_mode_e;

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_START,
        PH_DATA,
        PH_PARITY,
        PH_STOP
    } phase_e;

    typedef struct packed {
        logic [1:0]        len_code;
        par_mode_e         pmode;
        logic              ptype;
        logic [CODE_W-1:0] stop_code;
    } frame_cfg_t;

    // Stop period in ticks: short range, long range, and the 5-bit extension.
    function automatic logic [CNT_W-1:0] stop_ticks(input logic [CODE_W-1:0] code,
                                                    input logic [1:0] len_code);
        logic [CNT_W-1:0] n;
        n = CNT_W'(TICKS_PER_BIT / 2 + 1) + CNT_W'(code);
        if (code[CODE_W-1])
            n = n + CNT_W'(TICKS_PER_BIT / 2);
        else if (len_code == 2'b00)
            n = n + CNT_W'(TICKS_PER_BIT / 2);
        return n;
    endfunction

    // Index of the last data bit: 4 + len_code.
    function automatic logic [IDX_W-1:0] last_idx(input logic [1:0] len_code);
        return IDX_W'(4) + IDX_W'(len_code);
    endfunction

    function automatic logic extra_bit(input logic [MAX_DATA-1:0] data,
                                       input frame_cfg_t cfg);
        logic p;
        p = 1'b0;
        for (int i = 0; i < MAX_DATA; i++) begin
            if (IDX_W'(i) <= last_idx(cfg.len_code))
                p = p ^ data[i];
        end
        case (cfg.pmode)
            PAR_CALC: return cfg.ptype ? ~p : p;
            default:  return cfg.ptype;
        endcase
    endfunction

endpackage

// File: rtl/stx_hold.sv
module stx_hold
    import stx_pkg::*;
#(
    parameter int DW = MAX_DATA
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          wr,
    input  logic [DW-1:0] wdata,
    input  logic          enabled,
    input  logic          take,
    output logic          full,
    output logic [DW-1:0] data
);

    always_ff @(posedge clk) begin
        if (rst) begin
            full <= 1'b0;
            data <= '0;
        end else if (take) begin
            full <= 1'b0;
        end else if (wr && enabled && !full) begin
            full <= 1'b1;
            data <= wdata;
        end
    end

    AST_WR_IGNORED_DISABLED: assert property (@(posedge clk) disable iff (rst)
        (wr && !enabled && !take) |=> (full == $past(full))); // R5

    AST_TAKE_FROM_FULL: assert property (@(posedge clk) disable iff (rst)
        take |-> full); // R7

endmodule

// File: rtl/stx_shifter.sv
module stx_shifter
    import stx_pkg::*;
#(
    parameter int DW = MAX_DATA
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          tick,
    input  logic          start_ok,
    input  logic          cts_gate,
    input  logic          cts_in,
    input  logic [DW-1:0] hold_data,
    input  frame_cfg_t    cfg,
    output logic          take,
    output logic          busy,
    output logic          txd
);

    phase_e            phase;
    logic [CNT_W-1:0]  tcnt;
    logic [IDX_W-1:0]  bidx;
    logic [DW-1:0]     sreg;
    logic              pbit;
    logic              par_en;
    logic [1:0]        len_q;
    logic [CNT_W-1:0]  stop_len;
    logic              at_bit_end;
    logic              at_stop_end;
    logic [IDX_W-1:0]  bidx_n;

    always_comb begin
        at_bit_end  = (tcnt == CNT_W'(TICKS_PER_BIT - 1));
        at_stop_end = (tcnt == stop_len - CNT_W'(1));
        bidx_n      = bidx + IDX_W'(1);
        take        = tick && start_ok &&
                      ((phase == PH_IDLE) || (phase == PH_STOP && at_stop_end));
        busy        = (phase != PH_IDLE);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            phase    <= PH_IDLE;
            tcnt     <= '0;
            bidx     <= '0;
            sreg     <= '0;
            pbit     <= 1'b0;
            par_en   <= 1'b0;
            len_q    <= 2'b11;
            stop_len <= CNT_W'(TICKS_PER_BIT);
            txd      <= 1'b1;
        end else if (take) begin
            sreg     <= hold_data;
            pbit     <= extra_bit(hold_data, cfg);
            par_en   <= (cfg.pmode != PAR_NONE);
            len_q    <= cfg.len_code;
            stop_len <= stop_ticks(cfg.stop_code, cfg.len_code);
            phase    <= PH_START;
            tcnt     <= '0;
            bidx     <= '0;
            txd      <= 1'b0;
        end else if (tick) begin
            tcnt <= tcnt + CNT_W'(1);
            case (phase)
                PH_START: begin
                    if (at_bit_end) begin
                        phase <= PH_DATA;
                        tcnt  <= '0;
                        bidx  <= '0;
                        txd   <= sreg[0];
                    end
                end
                PH_DATA: begin
                    if (at_bit_end) begin
                        tcnt <= '0;
                        if (bidx == last_idx(len_q)) begin
                            if (par_en) begin
                                phase <= PH_PARITY;
                                txd   <= pbit;
                            end else begin
                                phase <= PH_STOP;
                                txd   <= 1'b1;
                            end
                        end else begin
                            bidx <= bidx_n;
                            txd  <= sreg[bidx_n];
                        end
                    end
                end
                PH_PARITY: begin
                    if (at_bit_end) begin
                        phase <= PH_STOP;
                        tcnt  <= '0;
                        txd   <= 1'b1;
                    end
                end
                PH_STOP: begin
                    if (at_stop_end) begin
                        phase <= PH_IDLE;
                        tcnt  <= '0;
                        txd   <= 1'b1;
                    end
                end
                default: begin
                    tcnt <= '0;
                    txd  <= 1'b1;
                end
            endcase
        end
    end

    AST_IDLE_MARK: assert property (@(posedge clk) disable iff (rst)
        (phase == PH_IDLE) |-> txd); // R1

    AST_STOP_MARK: assert property (@(posedge clk) disable iff (rst)
        (phase == PH_STOP) |-> txd); // R3

    AST_START_NEEDS_CTS: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |-> $past(!cts_gate || cts_in)); // R8

    AST_START_ON_TICK: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |-> $past(tick)); // R11

    AST_HOLD_WITHOUT_TICK: assert property (@(posedge clk) disable iff (rst)
        !tick |=> $stable(txd)); // R11

endmodule

// File: rtl/stx_rts.sv
module stx_rts (
    input  logic clk,
    input  logic rst,
    input  logic rts_set,
    input  logic rts_clr,
    input  logic rts_auto,
    input  logic emt,
    output logic rts_out
);

    logic emt_q;
    logic emt_rise;

    always_comb emt_rise = emt && !emt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            emt_q   <= 1'b1;
            rts_out <= 1'b0;
        end else begin
            emt_q <= emt;
            if (rts_set)
                rts_out <= 1'b1;
            else if (rts_clr || (rts_auto && emt_rise))
                rts_out <= 1'b0;
        end
    end

    AST_RTS_AUTO_DROP: assert property (@(posedge clk) disable iff (rst)
        (rts_auto && emt && !emt_q && !rts_set) |=> !rts_out); // R10

    AST_RTS_KEEP: assert property (@(posedge clk) disable iff (rst)
        (!rts_auto && !rts_clr && !rts_set) |=> $stable(rts_out)); // R10

endmodule

// File: rtl/serial_tx_chan.sv
module serial_tx_chan
    import stx_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       tick16,
    input  logic       cmd_tx_en,
    input  logic       cmd_tx_dis,
    input  logic       wr_en,
    input  logic [7:0] wr_data,
    input  logic [1:0] len_code,
    input  logic [1:0] par_mode,
    input  logic       par_type,
    input  logic [3:0] stop_code,
    input  logic       cts_gate,
    input  logic       cts_in,
    input  logic       rts_auto,
    input  logic       rts_set,
    input  logic       rts_clr,
    output logic       txd,
    output logic       tx_rdy,
    output logic       tx_emt,
    output logic       rts_out
);

    logic          enabled;
    logic          hold_full;
    logic [7:0]    hold_data;
    logic          take;
    logic          busy;
    logic          start_ok;
    frame_cfg_t    cfg;

    always_ff @(posedge clk) begin
        if (rst)
            enabled <= 1'b0;
        else if (cmd_tx_dis)
            enabled <= 1'b0;
        else if (cmd_tx_en)
            enabled <= 1'b1;
    end

    always_comb begin
        cfg.len_code  = len_code;
        cfg.pmode     = par_mode_e'(par_mode);
        cfg.ptype     = par_type;
        cfg.stop_code = stop_code;
        start_ok      = hold_full && enabled && (!cts_gate || cts_in);
        tx_rdy        = enabled && !hold_full;
        tx_emt        = !hold_full && !busy;
    end

    stx_hold #(.DW(8)) u_hold (
        .clk     (clk),
        .rst     (rst),
        .wr      (wr_en),
        .wdata   (wr_data),
        .enabled (enabled),
        .take    (take),
        .full    (hold_full),
        .data    (hold_data)
    );

    stx_shifter #(.DW(8)) u_shift (
        .clk       (clk),
        .rst       (rst),
        .tick      (tick16),
        .start_ok  (start_ok),
        .cts_gate  (cts_gate),
        .cts_in    (cts_in),
        .hold_data (hold_data),
        .cfg       (cfg),
        .take      (take),
        .busy      (busy),
        .txd       (txd)
    );

    stx_rts u_rts (
        .clk      (clk),
        .rst      (rst),
        .rts_set  (rts_set),
        .rts_clr  (rts_clr),
        .rts_auto (rts_auto),
        .emt      (tx_emt),
        .rts_out  (rts_out)
    );

    AST_EMT_MARK: assert property (@(posedge clk) disable iff (rst)
        tx_emt |-> txd); // R6

    AST_DISABLED_NOT_READY: assert property (@(posedge clk) disable iff (rst)
        cmd_tx_dis |=> !tx_rdy); // R9

endmodule

// File: tb/sim_serial_tx_chan.sv
module sim_serial_tx_chan;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       tick16 = 1'b1;
    logic       cmd_tx_en = 1'b0;
    logic       cmd_tx_dis = 1'b0;
    logic       wr_en = 1'b0;
    logic [7:0] wr_data = 8'h00;
    logic [1:0] len_code = 2'b11;
    logic [1:0] par_mode = 2'b10;
    logic       par_type = 1'b0;
    logic [3:0] stop_code = 4'd7;
    logic       cts_gate = 1'b0;
    logic       cts_in = 1'b0;
    logic       rts_auto = 1'b0;
    logic       rts_set = 1'b0;
    logic       rts_clr = 1'b0;
    logic       txd;
    logic       tx_rdy;
    logic       tx_emt;
    logic       rts_out;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    serial_tx_chan u0 (
        .clk(clk), .rst(rst), .tick16(tick16), .cmd_tx_en(cmd_tx_en),
        .cmd_tx_dis(cmd_tx_dis), .wr_en(wr_en), .wr_data(wr_data),
        .len_code(len_code), .par_mode(par_mode), .par_type(par_type),
        .stop_code(stop_code), .cts_gate(cts_gate), .cts_in(cts_in),
        .rts_auto(rts_auto), .rts_set(rts_set), .rts_clr(rts_clr),
        .txd(txd), .tx_rdy(tx_rdy), .tx_emt(tx_emt), .rts_out(rts_out)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual %0d expected %0d", tag, act, exp);
        end
    endtask

    function automatic int exp_stop(input int code, input int len);
        int n;
        n = 9 + code;
        if (code >= 8) n += 8;
        else if (len == 0) n += 8;
        return n;
    endfunction

    function automatic bit exp_extra(input logic [7:0] d, input int len, input int pm, input bit pt);
        bit p;
        if (pm != 0) return pt;
        p = 1'b0;
        for (int i = 0; i < 5 + len; i++) p ^= d[i];
        return pt ? ~p : p;
    endfunction

    function automatic bit exp_level(input int t, input logic [7:0] d, input int len,
                                     input int pm, input bit pt);
        int b;
        b = t / 16;
        if (b == 0) return 1'b0;
        if (b <= 5 + len) return d[b-1];
        return exp_extra(d, len, pm, pt);
    endfunction

    task automatic setcfg(input int len, input int pm, input bit pt, input int code);
        len_code = 2'(len);
        par_mode = 2'(pm);
        par_type = pt;
        stop_code = 4'(code);
    endtask

    task automatic pulse_en();
        cmd_tx_en = 1'b1; @(negedge clk); cmd_tx_en = 1'b0;
    endtask

    task automatic pulse_dis();
        cmd_tx_dis = 1'b1; @(negedge clk); cmd_tx_dis = 1'b0;
    endtask

    task automatic put_raw(input logic [7:0] d);
        wr_en = 1'b1; wr_data = d; @(negedge clk); wr_en = 1'b0;
    endtask

    task automatic put(input logic [7:0] d);
        int to;
        to = 0;
        while (!tx_rdy && to < 3000) begin @(negedge clk); to++; end
        put_raw(d);
    endtask

    task automatic check_frame(input logic [7:0] d, input bit nxt, input string tag);
        int to, len, pm, nb, total, bad, first;
        bit pt, e;
        len = int'(len_code); pm = int'(par_mode); pt = par_type;
        to = 0;
        while (txd !== 1'b0 && to < 3000) begin @(negedge clk); to++; end
        if (to >= 3000) begin
            chk(1'b0, {tag, " start bit never seen"}, 1, 0);
            return;
        end
        nb = 1 + 5 + len + ((pm != 2) ? 1 : 0);
        total = 16 * nb + exp_stop(int'(stop_code), len);
        bad = 0; first = -1;
        for (int t = 0; t < total; t++) begin
            e = (t < 16 * nb) ? exp_level(t, d, len, pm, pt) : 1'b1;
            if (txd !== e || tx_emt !== 1'b0) begin
                bad++;
                if (first < 0) first = t;
            end
            @(negedge clk);
        end
        chk(bad == 0, {tag, " frame shape (first bad tick)"}, first, -1);
        if (nxt)
            chk(txd == 1'b0, {tag, " R7 next start at stop end"}, int'(txd), 0);
        else
            chk(tx_emt == 1'b1 && txd == 1'b1, {tag, " tx_emt at stop end"}, int'(tx_emt), 1);
    endtask

    task automatic send(input logic [7:0] d, input string tag);
        fork
            put(d);
            check_frame(d, 1'b0, tag);
        join
    endtask

    initial begin
        repeat (180000) @(posedge clk);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog expired actual 1 expected 0");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        int hi_bad;
        logic [7:0] a, b;
        void'($urandom(32'd20240611));
        repeat (3) @(posedge clk);
        @(negedge clk) rst = 1'b0;

        // R6 / R1 reset state
        chk(txd == 1'b1, "R1 idle line after reset", int'(txd), 1);
        chk(tx_rdy == 1'b0, "R6 tx_rdy after reset (disabled)", int'(tx_rdy), 0);
        chk(tx_emt == 1'b1, "R6 tx_emt after reset", int'(tx_emt), 1);
        chk(rts_out == 1'b0, "R10 rts_out after reset", int'(rts_out), 0);

        // R5 write while disabled is dropped
        put_raw(8'hA5);
        hi_bad = 0;
        repeat (60) begin if (txd !== 1'b1 || tx_emt !== 1'b1) hi_bad++; @(negedge clk); end
        chk(hi_bad == 0, "R5 disabled write leaves line idle and empty", hi_bad, 0);
        pulse_en();
        chk(tx_rdy == 1'b1, "R6 tx_rdy after enable", int'(tx_rdy), 1);
        hi_bad = 0;
        repeat (60) begin if (txd !== 1'b1) hi_bad++; @(negedge clk); end
        chk(hi_bad == 0, "R5 dropped write not sent after enable", hi_bad, 0);

        // R11 no tick, no progress
        setcfg(3, 2, 0, 7);
        tick16 = 1'b0;
        put(8'h3C);
        hi_bad = 0;
        repeat (50) begin if (txd !== 1'b1) hi_bad++; @(negedge clk); end
        chk(hi_bad == 0, "R11 no start without tick", hi_bad, 0);
        chk(tx_emt == 1'b0 && tx_rdy == 1'b0, "R6 loaded char clears flags", int'(tx_emt), 0);
        tick16 = 1'b1;
        check_frame(8'h3C, 1'b0, "R11 frame after tick resumes");

        // R2 every parity mode and type
        for (int pm = 0; pm < 4; pm++)
            for (int pt = 0; pt < 2; pt++) begin
                setcfg(pm == 1 ? 1 : 3, pm, 1'(pt), 7);
                send(8'($urandom), "R2 parity mode");
            end

        // R3 / R4 every stop code with 5 and 8 data bits
        for (int code = 0; code < 16; code++) begin
            setcfg(3, 2, 0, code);
            send(8'($urandom), "R3 stop code 8-bit");
            setcfg(0, 0, 1'(code), code);
            send(8'($urandom), "R4 stop code 5-bit");
        end

        // R1 random characters and formats
        for (int k = 0; k < 30; k++) begin
            setcfg(int'($urandom % 4), int'($urandom % 4), 1'($urandom), int'($urandom % 16));
            send(8'($urandom), "R1 random frame");
        end

        // R7 back to back
        setcfg(2, 0, 0, 3);
        a = 8'h5A; b = 8'hC3;
        fork
            begin put(a); put(b); end
            begin check_frame(a, 1'b1, "R7 first of pair"); check_frame(b, 1'b0, "R7 second of pair"); end
        join

        // R8 CTS gating
        setcfg(3, 2, 0, 5);
        cts_gate = 1'b1; cts_in = 1'b0;
        put(8'h81);
        hi_bad = 0;
        repeat (50) begin if (txd !== 1'b1) hi_bad++; @(negedge clk); end
        chk(hi_bad == 0, "R8 held while CTS low", hi_bad, 0);
        chk(tx_rdy == 1'b0 && tx_emt == 1'b0, "R8 char pending while CTS low", int'(tx_rdy), 0);
        fork
            begin cts_in = 1'b1; repeat (40) @(negedge clk); cts_in = 1'b0; end
            check_frame(8'h81, 1'b0, "R8 CTS drop mid-char completes");
        join
        put(8'h42);
        hi_bad = 0;
        repeat (60) begin if (txd !== 1'b1) hi_bad++; @(negedge clk); end
        chk(hi_bad == 0, "R8 second char held while CTS low", hi_bad, 0);
        cts_in = 1'b1;
        check_frame(8'h42, 1'b0, "R8 frame after CTS asserted");
        cts_gate = 1'b0;

        // R9 disable mid character
        setcfg(1, 0, 1, 10);
        fork
            begin put(8'h2E); repeat (30) @(negedge clk); pulse_dis(); end
            check_frame(8'h2E, 1'b0, "R9 disable mid-char completes");
        join
        chk(tx_rdy == 1'b0, "R9 tx_rdy low while disabled", int'(tx_rdy), 0);
        pulse_en();

        // R10 request-to-send
        rts_set = 1'b1; @(negedge clk); rts_set = 1'b0;
        chk(rts_out == 1'b1, "R10 rts_set asserts", int'(rts_out), 1);
        rts_auto = 1'b1;
        setcfg(3, 2, 0, 0);
        send(8'h99, "R10 auto frame");
        chk(rts_out == 1'b1, "R10 rts still high as tx_emt rises", int'(rts_out), 1);
        @(negedge clk);
        chk(rts_out == 1'b0, "R10 auto release one clock after empty", int'(rts_out), 0);
        rts_auto = 1'b0;
        rts_set = 1'b1; @(negedge clk); rts_set = 1'b0;
        send(8'h11, "R10 manual frame");
        repeat (3) @(negedge clk);
        chk(rts_out == 1'b1, "R10 no release without auto", int'(rts_out), 1);
        rts_clr = 1'b1; @(negedge clk); rts_clr = 1'b0;
        chk(rts_out == 1'b0, "R10 rts_clr negates", int'(rts_out), 0);

        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule